// File: doc/BRIEF.md
# Addressed SPI Slave Front End with Pause

This block is the serial edge of a small peripheral that shares a four-wire SPI bus with up to three siblings. It oversamples the serial clock, chip select, pause and data lines with the core clock. A bit is captured on each rising serial-clock edge and the output bit changes on each falling edge, most-significant bit first. The first byte of every frame is an identification byte. It must carry a fixed four-bit type code, two zero bits and the two board-strapped address bits. When it matches, that byte and every byte after it are handed to a command layer. A byte from that layer is shifted back out on the serial output. When it does not match, the block stays silent until chip select rises.

A pause input lets the bus master stop a frame part-way and resume it later without losing bits. A change on the pause line counts only when it happens while the serial clock is low. While paused, clock edges are ignored and the partial byte is kept. After reset the block accepts nothing until chip select has made a high-to-low transition.

States: `ST_IDLE` (no frame; left only on a chip-select falling edge), `ST_ID` (collecting the identification byte), `ST_BODY` (address matched; bytes are delivered and the output may drive) and `ST_REJECT` (address mismatch; everything is ignored). The transitions are: idle to ID on a chip-select fall; ID to body on a matching eighth bit; ID to reject on a mismatching eighth bit; any of ID, body or reject back to idle when chip select is high.

Top module: `spi_hold_front`

## Requirements
- R1: Out of reset, `so_en_o`, `rx_valid_o` and `bit_valid_o` are low.
- R2: The data input is captured on a rising serial-clock edge. `so_o` changes only after a falling serial-clock edge, so it is steady while the clock is high.
- R3: While chip select is high, `so_en_o` is low and any partial byte is dropped. The next frame starts again from an identification byte with bit count zero.
- R4: After reset, no byte is delivered until chip select has gone from high to low. A chip select already low when reset ends does not open a frame.
- R5: The identification byte matches when bits 7:4 are 0101, bits 3:2 are 00 and bits 1:0 equal `addr_strap_i[1:0]`. A matching byte is delivered with index 0.
- R6: After a mismatching identification byte, no byte or bit is delivered and `so_en_o` stays low until chip select rises.
- R7: Bytes are received and sent most-significant bit first.
- R8: Each complete byte of a matched frame gives a one-cycle `rx_valid_o` pulse. Its index is 0 for the identification byte, 1 for the next byte, and 2 for every later byte.
- R9: On the falling edge that ends a byte of a matched frame, `tx_byte_i` and `tx_en_i` are loaded. That byte is driven MSB first during the next eight bit periods, and `so_en_o` follows the loaded `tx_en_i`.
- R10: A pause begins when `spi_hold_n_i` falls while the serial clock is low, and it ends when the input rises while the clock is low. In between, clock edges are ignored and the bit count and partial byte are kept.
- R11: A change of `spi_hold_n_i` while the serial clock is high has no effect on pausing.
- R12: Every data bit sampled after the second byte of a matched frame is also reported as a one-cycle `bit_valid_o` pulse with its value on `bit_value_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck_i | input | 1 | Serial clock |
| spi_cs_n_i | input | 1 | Active-low chip select |
| spi_si_i | input | 1 | Serial data from the master |
| spi_hold_n_i | input | 1 | Active-low pause request |
| addr_strap_i | input | 2 | Board-strapped device address |
| so_o | output | 1 | Serial data to the master |
| so_en_o | output | 1 | Output-drive enable; the pad is released when low |
| tx_byte_i | input | 8 | Byte from the command layer to send next |
| tx_en_i | input | 1 | Drive the output during the next byte |
| rx_valid_o | output | 1 | One-cycle pulse for a received byte |
| rx_byte_o | output | 8 | Received byte |
| rx_index_o | output | 2 | Byte position: 0 ID, 1 instruction, 2 data |
| bit_valid_o | output | 1 | One-cycle pulse for a streamed data bit |
| bit_value_o | output | 1 | Value of the streamed bit |

## Verification
The address check is tried with a matching byte and with three near misses: a wrong type nibble, a set pad bit and a wrong strap. This separates a full 8-bit compare from a partial one. A read frame drives a known pattern back and compares the output before and after each rising edge, which tells falling-edge launch apart from rising-edge launch. Pauses are entered once with the clock low and once with the clock high, with junk clocks during the low-clock pause. This shows whether edge-qualified entry and frozen counting are both present. An aborted partial byte and a frame opened without a chip-select fall after reset show whether state is dropped and whether the block arms correctly.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ID,
        ST_BODY,
        ST_REJECT
    } fe_state_t;
endpackage

// File: rtl/shf_edge.sv
module shf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic hold_n_i,
    output logic rise_o,
    output logic fall_o,
    output logic cs_fall_o,
    output logic paused_o
);
    logic sck_q, cs_q, hold_q, paused_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            cs_q     <= 1'b0;   // a low select at reset never reads as a fall
            hold_q   <= 1'b1;
            paused_q <= 1'b0;
        end else begin
            sck_q  <= sck_i;
            cs_q   <= cs_n_i;
            hold_q <= hold_n_i;
            if (cs_n_i)
                paused_q <= 1'b0;
            else if ((hold_n_i != hold_q) && !sck_i)
                paused_q <= !hold_n_i;
        end
    end

    logic live;
    assign live      = !cs_n_i && !paused_q;
    assign rise_o    = live && sck_i && !sck_q;
    assign fall_o    = live && !sck_i && sck_q;
    assign cs_fall_o = cs_q && !cs_n_i;
    assign paused_o  = paused_q;

    // R11: pause line moving while clock high leaves pause state alone
    a_r11_hold_ignored_sck_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((hold_n_i != hold_q) && sck_i && !cs_n_i) |=> $stable(paused_q));
    // R3: deselect clears any pause
    a_r3_cs_clears_pause: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> !paused_q);
endmodule

// File: rtl/shf_frame.sv
module shf_frame
    import spi_hold_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 2,
    parameter int TYPE_W = 4,
    parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              cs_fall_i,
    input  logic              rise_i,
    input  logic              paused_i,
    input  logic              si_i,
    input  logic [ADDR_W-1:0] addr_i,
    output fe_state_t         state_o,
    output logic              byte_start_o,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic [1:0]        rx_index_o,
    output logic              bit_valid_o,
    output logic              bit_value_o
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam int PAD_W = BYTE_W - TYPE_W - ADDR_W;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [1:0] IDX_DATA = 2'd2;

    fe_state_t         state_q, state_d;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [BYTE_W-2:0] sh_q;
    logic [1:0]        idx_q;
    logic              rx_valid_q, bit_valid_q, bit_value_q;
    logic [BYTE_W-1:0] rx_byte_q;
    logic [1:0]        rx_index_q;

    logic [BYTE_W-1:0] full;
    logic last, take, id_ok;
    assign full  = {sh_q, si_i};
    assign last  = (bitcnt_q == LAST_BIT);
    assign take  = rise_i && ((state_q == ST_ID) || (state_q == ST_BODY));
    assign id_ok = (full == {TYPE_CODE, {PAD_W{1'b0}}, addr_i});

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_fall_i) state_d = ST_ID;
            ST_ID:     if (cs_n_i) state_d = ST_IDLE;
                       else if (take && last) state_d = id_ok ? ST_BODY : ST_REJECT;
            ST_BODY:   if (cs_n_i) state_d = ST_IDLE;
            ST_REJECT: if (cs_n_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q    <= '0;
            sh_q        <= '0;
            idx_q       <= '0;
            rx_valid_q  <= 1'b0;
            rx_byte_q   <= '0;
            rx_index_q  <= '0;
            bit_valid_q <= 1'b0;
            bit_value_q <= 1'b0;
        end else begin
            rx_valid_q  <= 1'b0;
            bit_valid_q <= 1'b0;
            if (cs_n_i) begin
                bitcnt_q <= '0;
                sh_q     <= '0;
                idx_q    <= '0;
            end else if (take) begin
                bitcnt_q <= last ? '0 : bitcnt_q + CNT_W'(1);
                sh_q     <= full[BYTE_W-2:0];
                if ((state_q == ST_BODY) && (idx_q == IDX_DATA)) begin
                    bit_valid_q <= 1'b1;
                    bit_value_q <= si_i;
                end
                if (last && ((state_q == ST_BODY) || id_ok)) begin
                    rx_valid_q <= 1'b1;
                    rx_byte_q  <= full;
                    rx_index_q <= idx_q;
                    if (idx_q != IDX_DATA) idx_q <= idx_q + 2'd1;
                end
            end
        end
    end

    assign state_o      = state_q;
    assign byte_start_o = (bitcnt_q == '0);
    assign rx_valid_o   = rx_valid_q;
    assign rx_byte_o    = rx_byte_q;
    assign rx_index_o   = rx_index_q;
    assign bit_valid_o  = bit_valid_q;
    assign bit_value_o  = bit_value_q;

    // R6: a rejected frame delivers nothing
    a_r6_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REJECT) |=> (!rx_valid_q && !bit_valid_q));
    // R10: bit count frozen while paused
    a_r10_pause_freezes_count: assert property (@(posedge clk) disable iff (!rst_n)
        (paused_i && !cs_n_i) |=> $stable(bitcnt_q));
    // R8: byte strobe lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_q |=> !rx_valid_q);
    // R12: streamed bits only inside a matched frame
    a_r12_bits_in_body: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_q |-> (state_q == ST_BODY));
endmodule

// File: rtl/shf_tx.sv
module shf_tx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              fall_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic              tx_en_i,
    output logic              so_o,
    output logic              oe_o
);
    logic [BYTE_W-1:0] sh_q;
    logic so_q, oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
            so_q <= 1'b0;
            oe_q <= 1'b0;
        end else if (cs_n_i) begin
            sh_q <= '0;
            so_q <= 1'b0;
            oe_q <= 1'b0;
        end else if (fall_i) begin
            if (load_i) begin
                sh_q <= tx_byte_i;
                so_q <= tx_byte_i[BYTE_W-1];
                oe_q <= tx_en_i;
            end else begin
                sh_q <= sh_q << 1;
                so_q <= sh_q[BYTE_W-2];
            end
        end
    end

    assign so_o = so_q;
    assign oe_o = oe_q;

    // R2: output bit moves only on a falling serial edge
    a_r2_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_i && !cs_n_i) |=> $stable(so_q));
endmodule

// File: rtl/spi_hold_front.sv
module spi_hold_front
    import spi_hold_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 2,
    parameter int TYPE_W = 4,
    parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck_i,
    input  logic              spi_cs_n_i,
    input  logic              spi_si_i,
    input  logic              spi_hold_n_i,
    input  logic [ADDR_W-1:0] addr_strap_i,
    output logic              so_o,
    output logic              so_en_o,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic              tx_en_i,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic [1:0]        rx_index_o,
    output logic              bit_valid_o,
    output logic              bit_value_o
);
    logic rise, fall, cs_fall, paused, byte_start, oe;
    fe_state_t state;

    shf_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sck_i(spi_sck_i), .cs_n_i(spi_cs_n_i),
        .hold_n_i(spi_hold_n_i), .rise_o(rise), .fall_o(fall),
        .cs_fall_o(cs_fall), .paused_o(paused)
    );

    shf_frame #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .TYPE_CODE(TYPE_CODE)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_n_i(spi_cs_n_i), .cs_fall_i(cs_fall),
        .rise_i(rise), .paused_i(paused), .si_i(spi_si_i), .addr_i(addr_strap_i),
        .state_o(state), .byte_start_o(byte_start), .rx_valid_o(rx_valid_o),
        .rx_byte_o(rx_byte_o), .rx_index_o(rx_index_o),
        .bit_valid_o(bit_valid_o), .bit_value_o(bit_value_o)
    );

    shf_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .cs_n_i(spi_cs_n_i),
        .fall_i(fall && (state == ST_BODY)), .load_i(byte_start),
        .tx_byte_i(tx_byte_i), .tx_en_i(tx_en_i), .so_o(so_o), .oe_o(oe)
    );

    assign so_en_o = oe && (state == ST_BODY);

    // R3: deselect releases the output by the next cycle
    a_r3_release_on_cs: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n_i |=> !so_en_o);
    // R8: byte strobe never outside a matched frame
    a_r8_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (state == ST_BODY));
endmodule

// File: tb/spi_hold_front_tb.sv
`timescale 1ns/1ps
module spi_hold_front_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic [1:0] strap = 2'b10;
    logic [7:0] tx_byte = 8'h00;
    logic tx_en = 1'b0;
    logic so, so_en, rx_valid, bit_valid, bit_value;
    logic [7:0] rx_byte;
    logic [1:0] rx_index;

    always #2.5 clk = ~clk;

    spi_hold_front dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck_i(sck), .spi_cs_n_i(cs_n),
        .spi_si_i(si), .spi_hold_n_i(hold_n), .addr_strap_i(strap),
        .so_o(so), .so_en_o(so_en), .tx_byte_i(tx_byte), .tx_en_i(tx_en),
        .rx_valid_o(rx_valid), .rx_byte_o(rx_byte), .rx_index_o(rx_index),
        .bit_valid_o(bit_valid), .bit_value_o(bit_value)
    );

    int checks = 0, failures = 0;
    bit done = 1'b0;

    // passive monitor, sampled away from the active edge
    logic [7:0] rx_log [256];
    logic [1:0] idx_log [256];
    logic       bit_log [256];
    int rx_n = 0, bit_n = 0, en_n = 0;
    always @(negedge clk) begin
        if (rx_valid) begin
            rx_log[rx_n % 256]  = rx_byte;
            idx_log[rx_n % 256] = rx_index;
            rx_n++;
        end
        if (bit_valid) begin
            bit_log[bit_n % 256] = bit_value;
            bit_n++;
        end
        if (so_en) en_n++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one bit period; returns the output seen before the rise and before the fall
    task automatic spi_bit(input logic b, output logic pre, output logic mid, output logic en_pre);
        si = b;
        wclk(3);
        pre = so; en_pre = so_en;
        sck = 1'b1;
        wclk(3);
        mid = so;
        sck = 1'b0;
        wclk(3);
    endtask

    task automatic spi_byte(input logic [7:0] v, output logic [7:0] got, output int en_bits, output int moved);
        logic p, m, e;
        en_bits = 0; moved = 0;
        for (int i = 7; i >= 0; i--) begin
            spi_bit(v[i], p, m, e);
            got[i] = p;
            if (e) en_bits++;
            if (p != m) moved++;
        end
    endtask

    task automatic send(input logic [7:0] v);
        logic [7:0] g; int e, m;
        spi_byte(v, g, e, m);
    endtask

    task automatic cs_open;
        cs_n = 1'b1; wclk(4); cs_n = 1'b0; wclk(4);
    endtask

    task automatic cs_close;
        cs_n = 1'b1; wclk(6);
    endtask

    task automatic t_reset_and_arm;
        int b;
        cs_n = 1'b0;   // select already low when reset ends
        wclk(4);
        rst_n = 1'b1;
        wclk(2);
        check(!so_en && !rx_valid && !bit_valid, "R1 reset outputs", {so_en, rx_valid, bit_valid}, 0);
        b = rx_n;
        send(8'h52); send(8'h3C);
        check(rx_n == b, "R4 no frame without cs fall", rx_n - b, 0);
        cs_close;
    endtask

    task automatic t_match;
        int b, bb;
        strap = 2'b10;
        b = rx_n; bb = bit_n;
        cs_open;
        send(8'h52); send(8'h3C); send(8'hC1);
        wclk(2);
        check(rx_n - b == 3, "R8 three bytes", rx_n - b, 3);
        check(rx_log[b%256] == 8'h52 && idx_log[b%256] == 2'd0, "R5 id byte index 0", {idx_log[b%256], rx_log[b%256]}, 12'h052);
        check(rx_log[(b+1)%256] == 8'h3C && idx_log[(b+1)%256] == 2'd1, "R8 instruction index 1", {idx_log[(b+1)%256], rx_log[(b+1)%256]}, 12'h13C);
        check(rx_log[(b+2)%256] == 8'hC1 && idx_log[(b+2)%256] == 2'd2, "R7 data byte MSB first index 2", {idx_log[(b+2)%256], rx_log[(b+2)%256]}, 12'h2C1);
        check(bit_n - bb == 8, "R12 eight streamed bits", bit_n - bb, 8);
        begin
            logic [7:0] s;
            for (int i = 0; i < 8; i++) s[7-i] = bit_log[(bb+i)%256];
            check(s == 8'hC1, "R12 streamed bit order", s, 8'hC1);
        end
        send(8'h0F);
        wclk(2);
        check(idx_log[(b+3)%256] == 2'd2, "R8 later byte stays index 2", idx_log[(b+3)%256], 2);
        cs_close;
    endtask

    task automatic t_mismatch(input logic [7:0] id, input string tag);
        int b, bb, e;
        strap = 2'b01;
        tx_byte = 8'hFF; tx_en = 1'b1;
        b = rx_n; bb = bit_n; e = en_n;
        cs_open;
        send(id); send(8'h3C); send(8'hAA);
        wclk(2);
        check(rx_n == b && bit_n == bb, {"R6 no delivery ", tag}, rx_n - b, 0);
        check(en_n == e, {"R6 output released ", tag}, en_n - e, 0);
        cs_close;
        tx_en = 1'b0;
    endtask

    task automatic t_read;
        logic [7:0] g; int eb, mv;
        strap = 2'b01;
        tx_en = 1'b0;
        cs_open;
        send(8'h51);
        tx_byte = 8'hA5; tx_en = 1'b1;
        spi_byte(8'h80, g, eb, mv);
        check(eb == 0, "R9 no drive during instruction", eb, 0);
        tx_byte = 8'h00; tx_en = 1'b0;
        spi_byte(8'h00, g, eb, mv);
        check(g == 8'hA5, "R9 R7 read data MSB first", g, 8'hA5);
        check(eb == 8, "R9 drive during data byte", eb, 8);
        check(mv == 0, "R2 output steady across rise", mv, 0);
        cs_n = 1'b1; wclk(2);
        check(!so_en, "R3 output released on deselect", so_en, 0);
        wclk(4);
    endtask

    task automatic t_hold_low;
        int b; logic p, m, e;
        logic [7:0] v = 8'hB6;
        strap = 2'b10;
        b = rx_n;
        cs_open;
        send(8'h52);
        for (int i = 7; i >= 5; i--) spi_bit(v[i], p, m, e);
        hold_n = 1'b0; wclk(3);
        for (int i = 0; i < 3; i++) spi_bit(1'b0, p, m, e);   // junk while paused
        hold_n = 1'b1; wclk(3);
        check(rx_n - b == 1, "R10 no byte during pause", rx_n - b, 1);
        for (int i = 4; i >= 0; i--) spi_bit(v[i], p, m, e);
        wclk(2);
        check(rx_n - b == 2 && rx_log[(b+1)%256] == 8'hB6, "R10 byte resumes intact", rx_log[(b+1)%256], 8'hB6);
        cs_close;
    endtask

    task automatic bit_hold_high(input logic b, input logic h);
        si = b; wclk(3);
        sck = 1'b1; wclk(2);
        hold_n = h; wclk(2);
        sck = 1'b0; wclk(3);
    endtask

    task automatic t_hold_high;
        int b; logic p, m, e;
        logic [7:0] v = 8'h6D;
        strap = 2'b10;
        b = rx_n;
        cs_open;
        send(8'h52);
        bit_hold_high(v[7], 1'b0);          // pause line drops with clock high
        for (int i = 6; i >= 2; i--) spi_bit(v[i], p, m, e);
        bit_hold_high(v[1], 1'b1);          // and rises with clock high
        spi_bit(v[0], p, m, e);
        wclk(2);
        check(rx_n - b == 2 && rx_log[(b+1)%256] == 8'h6D, "R11 clock-high pause ignored", rx_log[(b+1)%256], 8'h6D);
        cs_close;
    endtask

    task automatic t_abort;
        int b; logic p, m, e;
        strap = 2'b10;
        cs_open;
        send(8'h52);
        for (int i = 0; i < 4; i++) spi_bit(1'b1, p, m, e);
        cs_close;
        b = rx_n;
        cs_n = 1'b0; wclk(4);
        send(8'h52); send(8'h3C);
        wclk(2);
        check(rx_n - b == 2 && rx_log[(b+1)%256] == 8'h3C && idx_log[(b+1)%256] == 2'd1,
              "R3 partial byte discarded", rx_log[(b+1)%256], 8'h3C);
        cs_close;
    endtask

    initial begin
        t_reset_and_arm;
        t_match;
        t_mismatch(8'h71, "type");
        t_mismatch(8'h55, "pad");
        t_mismatch(8'h52, "strap");
        t_read;
        t_hold_low;
        t_hold_high;
        t_abort;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule